// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Cascaded Prescalers

This block generates four independent pulse-width modulated outputs. A small word-wide register bus configures it. Each channel divides the system clock into a step clock. It does this with two cascaded sub-divider stages, one dividing by 8 and one by 64, used singly, together, or not at all. An 8-bit period count (timebase) sets the number of steps in one period. An 8-bit duty count sets how many of the first steps of each period drive the output high.

Software loads the per-channel timebase and duty words, then sets the channel's enable bit and prescaler select in the shared control word. Values written while a channel runs are captured only at the end of the current period, so each output period is whole. A separate mode word holds one bit per channel. When a channel's bit is clear, its pulse train reaches the output pin. When the bit is set, the pin is held low, because the alternate modulation is not built here.

Top module: `pwm_quad`

## Requirements
- R1: The control word at byte offset 0x000 holds the run enable of channel n in bit n (bits 3:0) and its 2-bit prescaler select in bits 5+2n:4+2n; it reads back exactly these 12 bits, and a disabled channel's output stays low.
- R2: Prescaler select 0 gives one clock per step, 1 gives 8 clocks per step, 2 gives 64, and 3 cascades both stages for 512 clocks per step.
- R3: The configuration word of channel n sits at byte offset 0x004 + 4n, with the timebase in bits 7:0 and the duty in bits 23:16; all other bits read zero.
- R4: An enabled channel's period lasts timebase steps, and its output is high during the first min(duty, timebase) steps of each period. A duty of 0 gives a constant low output, and a duty at or above the timebase gives a constant high output.
- R5: A timebase of 0 holds the output low whatever the duty.
- R6: Clearing a channel's enable drives its output low at once and clears its step and prescaler counters. The clock cycle after the write that sets the enable is step 0 of a fresh period.
- R7: A timebase, duty or prescaler change written to a running channel takes effect at the first period boundary after the write. A write that lands on the clock edge of a boundary takes effect one period later.
- R8: The mode word at byte offset 0x140 holds one bit per channel at bit 4n and resets to zero. A set bit forces that channel's pin low, and a clear bit passes the pulse train.
- R9: All registers reset to zero. Reads of unmapped or misaligned offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the prescaler input |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier; a write happens on the rising edge while bus_sel and bus_wr are high |
| bus_addr | input | 9 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr while bus_sel is high, zero otherwise |
| pwm_out | output | 4 | One pulse output per channel |

## Verification
The risky coincidence is a configuration write that lands on the same clock edge as a channel's period wrap. The shadow copy must then take the value held before that edge, not the value being written. The bench first runs a channel with a one-clock step. It then changes the duty once in mid-period and once exactly on the wrap edge. It judges each case by the number of high cycles in the periods that follow. The mid-period write must appear in the next period, and the wrap-edge write must appear one period later.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int NUM_CH   = 4;
  localparam int STEP_W   = 8;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 9;
  localparam int PSEL_W   = 2;
  localparam int DIV0_LOG = 3;   // first sub-divider, /8
  localparam int DIV1_LOG = 6;   // second sub-divider, /64

  localparam logic [ADDR_W-1:0] OFS_CTRL = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_CFG0 = 9'h004;
  localparam logic [ADDR_W-1:0] OFS_MODE = 9'h140;
  localparam int CTRL_PS_LSB  = 4;
  localparam int CFG_DUTY_LSB = 16;
  localparam int MODE_STRIDE  = 4;

  function automatic logic [ADDR_W-1:0] cfg_addr(input int n);
    return ADDR_W'(OFS_CFG0 + 4 * n);
  endfunction

  // Output level for a given step position within one period.
  function automatic logic pulse_level(input logic [STEP_W-1:0] step,
                                       input logic [STEP_W-1:0] tbase,
                                       input logic [STEP_W-1:0] duty);
    return (tbase != '0) && (step < duty);
  endfunction

  // Final step of a period; a zero timebase wraps on every step.
  function automatic logic last_step(input logic [STEP_W-1:0] step,
                                     input logic [STEP_W-1:0] tbase);
    return (tbase == '0) || (step == tbase - 1'b1);
  endfunction
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int TBW = STEP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NCH-1:0]        en,
  output logic [NCH*PSEL_W-1:0] psel,
  output logic [NCH*TBW-1:0]    tbase,
  output logic [NCH*TBW-1:0]    duty,
  output logic [NCH-1:0]        mode
);
  logic do_wr;
  assign do_wr = bus_sel && bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= '0;
      psel  <= '0;
      tbase <= '0;
      duty  <= '0;
      mode  <= '0;
    end else if (do_wr) begin
      for (int n = 0; n < NCH; n++) begin
        if (bus_addr == OFS_CTRL) begin
          en[n]                  <= bus_wdata[n];
          psel[PSEL_W*n +: PSEL_W] <= bus_wdata[CTRL_PS_LSB + PSEL_W*n +: PSEL_W];
        end
        if (bus_addr == cfg_addr(n)) begin
          tbase[TBW*n +: TBW] <= bus_wdata[TBW-1:0];
          duty[TBW*n +: TBW]  <= bus_wdata[CFG_DUTY_LSB +: TBW];
        end
        if (bus_addr == OFS_MODE)
          mode[n] <= bus_wdata[MODE_STRIDE*n];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      for (int n = 0; n < NCH; n++) begin
        if (bus_addr == OFS_CTRL) begin
          bus_rdata[n] = en[n];
          bus_rdata[CTRL_PS_LSB + PSEL_W*n +: PSEL_W] = psel[PSEL_W*n +: PSEL_W];
        end
        if (bus_addr == cfg_addr(n)) begin
          bus_rdata[TBW-1:0]             = tbase[TBW*n +: TBW];
          bus_rdata[CFG_DUTY_LSB +: TBW] = duty[TBW*n +: TBW];
        end
        if (bus_addr == OFS_MODE)
          bus_rdata[MODE_STRIDE*n] = mode[n];
      end
    end
  end
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
#(
  parameter int TBW   = STEP_W,
  parameter int D0LOG = DIV0_LOG,
  parameter int D1LOG = DIV1_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PSEL_W-1:0] psel,
  input  logic [TBW-1:0]    tbase,
  input  logic [TBW-1:0]    duty,
  input  logic              mode,
  output logic              pin,
  output logic              wrap,
  output logic              run,
  output logic [TBW-1:0]    cur_duty
);
  logic [D0LOG-1:0]  sub0;
  logic [D1LOG-1:0]  sub1;
  logic [TBW-1:0]    step;
  logic [TBW-1:0]    sh_tb, sh_duty;
  logic [PSEL_W-1:0] sh_ps;
  logic [TBW-1:0]    eff_tb;
  logic [PSEL_W-1:0] eff_ps;
  logic              tick0, step_tick, at_end;

  // First enabled cycle uses the live registers; afterwards the shadows.
  assign eff_tb   = run ? sh_tb   : tbase;
  assign cur_duty = run ? sh_duty : duty;
  assign eff_ps   = run ? sh_ps   : psel;

  // Cascaded sub-dividers: bit 0 selects /8, bit 1 selects /64.
  assign tick0     = eff_ps[0] ? (sub0 == '1) : 1'b1;
  assign step_tick = eff_ps[1] ? (tick0 && (sub1 == '1)) : tick0;
  assign at_end    = last_step(step, eff_tb);
  assign wrap      = en && step_tick && at_end;
  assign pin       = en && !mode && pulse_level(step, eff_tb, cur_duty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      sub0    <= '0;
      sub1    <= '0;
      step    <= '0;
      sh_tb   <= '0;
      sh_duty <= '0;
      sh_ps   <= '0;
    end else if (!en) begin
      run  <= 1'b0;
      sub0 <= '0;
      sub1 <= '0;
      step <= '0;
    end else begin
      run <= 1'b1;
      if (eff_ps[0])
        sub0 <= sub0 + 1'b1;
      if (eff_ps[1] && tick0)
        sub1 <= sub1 + 1'b1;
      if (step_tick)
        step <= at_end ? '0 : step + 1'b1;
      if (!run || wrap) begin
        sh_tb   <= tbase;
        sh_duty <= duty;
        sh_ps   <= psel;
      end
    end
  end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int TBW = STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0]        ctl_en;
  logic [NCH-1:0]        ctl_mode;
  logic [NCH*PSEL_W-1:0] ctl_psel;
  logic [NCH*TBW-1:0]    ctl_tbase;
  logic [NCH*TBW-1:0]    ctl_duty;
  logic [NCH-1:0]        ch_wrap;
  logic [NCH-1:0]        ch_run;
  logic [NCH*TBW-1:0]    ch_duty;

  pwm_quad_regs #(.NCH(NCH), .TBW(TBW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .en       (ctl_en),
    .psel     (ctl_psel),
    .tbase    (ctl_tbase),
    .duty     (ctl_duty),
    .mode     (ctl_mode)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pwm_quad_chan #(.TBW(TBW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctl_en[n]),
      .psel    (ctl_psel[PSEL_W*n +: PSEL_W]),
      .tbase   (ctl_tbase[TBW*n +: TBW]),
      .duty    (ctl_duty[TBW*n +: TBW]),
      .mode    (ctl_mode[n]),
      .pin     (pwm_out[n]),
      .wrap    (ch_wrap[n]),
      .run     (ch_run[n]),
      .cur_duty(ch_duty[TBW*n +: TBW])
    );
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
  import pwm_quad_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int TBW = STEP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH-1:0]    en,
  input logic [NCH-1:0]    mode,
  input logic [NCH-1:0]    run,
  input logic [NCH-1:0]    wrap,
  input logic [NCH*TBW-1:0] cur_duty
);
  logic mapped;
  always_comb begin
    mapped = (bus_addr == 9'h000) || (bus_addr == 9'h140);
    if (bus_addr[1:0] == 2'b00 && bus_addr >= 9'h004 &&
        int'(bus_addr) <= 4 * NCH)
      mapped = 1'b1;
  end

  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !mapped) |-> (bus_rdata == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en[n] |-> !pwm_out[n]);

    a_r8_mode_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      mode[n] |-> !pwm_out[n]);

    a_r7_duty_held_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      (run[n] && $past(run[n]) && !$past(wrap[n])) |->
        $stable(cur_duty[TBW*n +: TBW]));

    a_r6_restart_fresh: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en[n]) |-> !run[n]);
  end
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH), .TBW(TBW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .pwm_out  (pwm_out),
  .en       (ctl_en),
  .mode     (ctl_mode),
  .run      (ch_run),
  .wrap     (ch_wrap),
  .cur_duty (ch_duty)
);

// File: tb/pwm_quad_tb.sv
module pwm_quad_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  pwm_quad u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // Vector: {channel[1:0], prescale[1:0], timebase[7:0], duty[7:0]}
  localparam logic [19:0] VEC [9] = '{
    {2'd0, 2'd0, 8'd5,   8'd2},
    {2'd1, 2'd1, 8'd4,   8'd1},
    {2'd2, 2'd2, 8'd3,   8'd2},
    {2'd3, 2'd3, 8'd2,   8'd1},
    {2'd1, 2'd0, 8'd6,   8'd6},
    {2'd2, 2'd0, 8'd6,   8'd200},
    {2'd3, 2'd0, 8'd7,   8'd0},
    {2'd0, 2'd1, 8'd0,   8'd3},
    {2'd0, 2'd0, 8'd255, 8'd128}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // Samples n cycles from the current falling edge; counts highs on channel ch
  // and highs on every other channel.
  task automatic count(input int n, input int ch, output int hi, output int other);
    hi = 0; other = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[ch]) hi++;
      for (int k = 0; k < 4; k++)
        if (k != ch && pwm_out[k]) other++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi, oth;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R9, R8, R6)
    rd(9'h000, d); check("R9 ctrl reset", d, 0);
    rd(9'h004, d); check("R9 cfg reset", d, 0);
    rd(9'h140, d); check("R8 mode reset", d, 0);
    check("R6 outputs low after reset", {28'd0, pwm_out}, 0);

    // Readback masks (R1, R3, R8)
    wr(9'h000, 32'hFFFF_FFFF); rd(9'h000, d); check("R1 ctrl mask", d, 32'h0000_0FFF);
    wr(9'h000, 32'h0);
    wr(9'h00C, 32'hFFFF_FFFF); rd(9'h00C, d); check("R3 cfg mask", d, 32'h00FF_00FF);
    wr(9'h140, 32'hFFFF_FFFF); rd(9'h140, d); check("R8 mode mask", d, 32'h0000_1111);
    wr(9'h140, 32'h0);

    // Unmapped and misaligned offsets (R9)
    wr(9'h040, 32'hFFFF_FFFF); rd(9'h040, d); check("R9 unmapped 0x040", d, 0);
    wr(9'h144, 32'hFFFF_FFFF); rd(9'h144, d); check("R9 unmapped 0x144", d, 0);
    wr(9'h00E, 32'h0000_0000); rd(9'h00E, d); check("R9 misaligned read", d, 0);
    rd(9'h00C, d); check("R9 cfg untouched by stray writes", d, 32'h00FF_00FF);
    rd(9'h000, d); check("R9 ctrl untouched by stray writes", d, 0);
    wr(9'h00C, 32'h0);

    // Vector table: period, duty and prescaler (R2, R4, R5, R1)
    for (int v = 0; v < 9; v++) begin
      int ch, ps, tb, du, dv, win, exp_hi;
      string tag;
      ch = int'(VEC[v][19:18]); ps = int'(VEC[v][17:16]);
      tb = int'(VEC[v][15:8]);  du = int'(VEC[v][7:0]);
      dv = 1 << (3 * ps);
      if (tb == 0) begin win = 40; exp_hi = 0; tag = "R5 zero timebase"; end
      else begin
        win = 2 * tb * dv;
        exp_hi = 2 * ((du < tb) ? du : tb) * dv;
        tag = (ps != 0) ? "R2 prescaled high count" : "R4 high count";
      end
      wr(9'(4 + 4 * ch), (du << 16) | tb);
      wr(9'h000, (1 << ch) | (ps << (4 + 2 * ch)));
      check("R6 first step level", {31'd0, pwm_out[ch]}, {31'd0, (tb != 0 && du != 0)});
      count(win, ch, hi, oth);
      check(tag, hi, exp_hi);
      check("R1 idle channels low", oth, 0);
      wr(9'h000, 32'h0);
    end

    // Update timing: mid-period and on the wrap edge (R7)
    wr(9'h004, 32'h0002_0008);
    wr(9'h000, 32'h1);
    count(3, 0, hi, oth); check("R7 first period head", hi, 2);
    wr(9'h004, 32'h0006_0008);                    // lands mid-period
    count(4, 0, hi, oth); check("R7 rest of period unchanged", hi, 0);
    count(7, 0, hi, oth); check("R7 new duty next period", hi, 6);
    wr(9'h004, 32'h0003_0008);                    // lands on the wrap edge
    count(8, 0, hi, oth); check("R7 wrap-edge write deferred", hi, 6);
    count(8, 0, hi, oth); check("R7 wrap-edge write applied", hi, 3);
    wr(9'h000, 32'h0);

    // Mode gating (R8)
    wr(9'h004, 32'h0008_0008);
    wr(9'h000, 32'h1);
    check("R4 full duty high", {31'd0, pwm_out[0]}, 1);
    wr(9'h140, 32'h1);
    count(10, 0, hi, oth); check("R8 mode bit forces low", hi, 0);
    rd(9'h140, d); check("R8 mode readback", d, 1);
    wr(9'h140, 32'h10);
    check("R8 other channel bit leaves ch0", {31'd0, pwm_out[0]}, 1);
    wr(9'h140, 32'h0);

    // Disable and restart (R6)
    wr(9'h000, 32'h0);
    wr(9'h004, 32'h0001_0004);
    wr(9'h000, 32'h1);
    count(2, 0, hi, oth);
    wr(9'h000, 32'h0);
    count(6, 0, hi, oth); check("R6 disabled output low", hi, 0);
    wr(9'h000, 32'h1);
    check("R6 restart at step 0", {31'd0, pwm_out[0]}, 1);
    count(4, 0, hi, oth); check("R6 restart period", hi, 1);
    wr(9'h000, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule